// File: doc/BRIEF.md
# Serial-Programmed Divider Configuration Target

This block is the configuration front end of a frequency synthesizer. It holds the active divider settings (a 10-bit feedback divider M, a 3-bit output divider code NA, a one-bit divider select NB and a one-bit prescaler select P) and drives them to the analog core. It also acts as a target on a two-wire serial bus. The bus lines are sampled by the system clock, and the data line is driven open-drain. Software reaches two 8-bit staging registers through this bus. Command writes copy the staging values into the active settings, copy the active settings back into staging, or step M up or down.

Two sources set the active settings. When the master-reset input goes from low to high, the block captures the parallel divider pins. This happens in either mode. While the mode input is low, the settings track the parallel pins all the time. While it is high, only serial commands change them. A read transfer never writes a register pointer first. It returns the low staging byte and then the high staging byte, and it repeats that pair for as long as the controller keeps acknowledging.

Top module: `synth_cfg_i2c`

## Requirements
- R1: The block acknowledges only the 7-bit address made of the prefix 10110 followed by `addr_sel[1]` and `addr_sel[0]`. It leaves every other address unacknowledged and does not react to it.
- R2: A read transfer returns the low staging byte first and the high staging byte second. The low byte carries M[7:0]. The high byte carries M[9:8] in bits 1:0, NA in bits 4:2, NB in bit 5 and P in bit 6. Bit 7 always reads 0.
- R3: In a write transfer, the first byte after the address is a command. The second byte goes to the low staging register and the third byte goes to the high staging register. Any further bytes are acknowledged and discarded. Writing staging alone leaves the active settings unchanged.
- R4: Command 0x01 copies the staging pair into the active settings when the mode input is high.
- R5: Command 0x02 copies the active settings into the staging pair. This works in both modes.
- R6: Command 0x03 raises M by one and stops at 1023. Command 0x04 lowers M by one and stops at 0. Neither command touches the staging registers.
- R7: Any other command code is acknowledged and changes neither the active settings nor the staging registers.
- R8: After the system reset, the active settings are M=500, NA=2, NB=0 and P=1, the staging pair reads 0xF4 then 0x49, and the data line is released.
- R9: A low-to-high transition of `mr_n` loads the parallel pins into the active settings in either mode. While `mr_n` is low, the active settings hold their value.
- R10: While `pload` is low, the active settings follow the parallel pins and commands do not change them. While `pload` is high, changes on the pins are ignored. `serial_mode` reports the synchronized `pload`.
- R11: A STOP or a repeated START in the middle of a byte discards that byte with no register effect and releases the data line. A repeated START begins a new address phase.
- R12: The command register cannot be read. A read that follows a command write still returns the staging pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Pull the data line low when 1 |
| addr_sel | input | 2 | Low two bits of the target address |
| mr_n | input | 1 | Master reset; its rising edge captures the parallel pins |
| pload | input | 1 | Mode select: 0 means the pins drive the settings, 1 means serial commands do |
| par_m | input | 10 | Parallel M divider pins |
| par_na | input | 3 | Parallel NA divider pins |
| par_nb | input | 1 | Parallel NB pin |
| par_p | input | 1 | Parallel P pin |
| m_out | output | 10 | Active M divider |
| na_out | output | 3 | Active NA divider |
| nb_out | output | 1 | Active NB select |
| p_out | output | 1 | Active P select |
| serial_mode | output | 1 | Synchronized mode select |

## Verification
The hardest state to reach is a transfer cut off in the middle of a byte. A STOP or a repeated START has to land while the target holds a partial shift register, and the bench must then show that neither the staging pair nor the active settings changed. The bench's bit-level controller tasks send a chosen number of data bits and then issue the STOP or START condition with the clock high. A complete read transfer afterwards confirms that the staging pair is unchanged, and the output ports confirm that the active settings are unchanged. The saturation limits of M are reached by first loading 1023 or 0 through the staging pair and then sending the step command.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int M_W  = 10;
  localparam int NA_W = 3;

  typedef struct packed {
    logic            p;
    logic            nb;
    logic [NA_W-1:0] na;
    logic [M_W-1:0]  m;
  } div_cfg_t;

  localparam div_cfg_t DEF_CFG = '{p: 1'b1, nb: 1'b0, na: 3'd2, m: 10'd500};
  localparam logic [M_W-1:0] M_MAX = {M_W{1'b1}};

  localparam logic [7:0] OP_LOAD = 8'h01;
  localparam logic [7:0] OP_GET  = 8'h02;
  localparam logic [7:0] OP_INC  = 8'h03;
  localparam logic [7:0] OP_DEC  = 8'h04;

  typedef enum logic [2:0] {
    TS_IDLE, TS_ADDR, TS_AACK, TS_WR, TS_WACK, TS_RD, TS_RACK
  } tgt_state_t;

  // staging word layout: {rsvd, p, nb, na, m}
  function automatic logic [15:0] cfg_to_word(div_cfg_t c);
    return {1'b0, c};
  endfunction

  function automatic div_cfg_t word_to_cfg(logic [15:0] w);
    return div_cfg_t'(w[14:0]);
  endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL[g]}};
      else        pipe_q <= {pipe_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/line_events.sv
module line_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic mr_n_in,
  input  logic pload_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic mr_s,
  output logic mr_rise,
  output logic pload_s
);
  logic [3:0] synced;
  logic scl_s, scl_d, sda_d, mr_d;

  bus_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(4'b1111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw({pload_in, mr_n_in, sda_in, scl_in}),
    .synced(synced)
  );

  assign scl_s   = synced[0];
  assign sda_s   = synced[1];
  assign mr_s    = synced[2];
  assign pload_s = synced[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      mr_d  <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      mr_d  <= mr_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign mr_rise   = mr_s & ~mr_d;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import synth_cfg_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = 5'b10110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] addr_sel,
  input  logic [7:0] rd_lo,
  input  logic [7:0] rd_hi,
  output logic       sda_oe,
  output logic       wr_strobe,
  output logic [1:0] wr_idx,
  output logic [7:0] wr_data
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(8);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(7);

  tgt_state_t st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic [1:0] idx_q, idx_n;
  logic rw_q, rw_n, nack_q, nack_n, oe_q, oe_n, rdsel_q, rdsel_n;
  logic [7:0] next_rd;

  assign next_rd = rdsel_q ? rd_lo : rd_hi;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; idx_n = idx_q;
    rw_n = rw_q; nack_n = nack_q; oe_n = oe_q; rdsel_n = rdsel_q;
    wr_strobe = 1'b0;
    if (stop_det) begin
      st_n = TS_IDLE; oe_n = 1'b0;
    end else if (start_det) begin
      st_n = TS_ADDR; oe_n = 1'b0; cnt_n = '0;
    end else begin
      unique case (st_q)
        TS_ADDR: begin
          if (scl_rise) begin
            sh_n = {sh_q[6:0], sda_s}; cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (sh_q[7:1] == {ADDR_PREFIX, addr_sel}) begin
              st_n = TS_AACK; oe_n = 1'b1; rw_n = sh_q[0];
            end else begin
              st_n = TS_IDLE;
            end
          end
        end
        TS_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw_q) begin
              st_n = TS_RD; rdsel_n = 1'b0; sh_n = rd_lo; oe_n = ~rd_lo[7];
            end else begin
              st_n = TS_WR; oe_n = 1'b0; idx_n = '0;
            end
          end
        end
        TS_WR: begin
          if (scl_rise) begin
            sh_n = {sh_q[6:0], sda_s}; cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            wr_strobe = 1'b1; st_n = TS_WACK; oe_n = 1'b1;
          end
        end
        TS_WACK: begin
          if (scl_fall) begin
            st_n = TS_WR; oe_n = 1'b0; cnt_n = '0;
            if (idx_q != 2'd3) idx_n = idx_q + 1'b1;
          end
        end
        TS_RD: begin
          if (scl_fall) begin
            if (cnt_q == LAST) begin
              st_n = TS_RACK; oe_n = 1'b0;
            end else begin
              cnt_n = cnt_q + 1'b1; sh_n = {sh_q[6:0], 1'b0}; oe_n = ~sh_q[6];
            end
          end
        end
        TS_RACK: begin
          if (scl_rise) begin
            nack_n = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_n = TS_IDLE;
            end else begin
              st_n = TS_RD; rdsel_n = ~rdsel_q; sh_n = next_rd;
              oe_n = ~next_rd[7]; cnt_n = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_n_reg_reset: begin
        st_q <= TS_IDLE; cnt_q <= '0; sh_q <= '0; idx_q <= '0;
        rw_q <= 1'b0; nack_q <= 1'b0; oe_q <= 1'b0; rdsel_q <= 1'b0;
      end
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; idx_q <= idx_n;
      rw_q <= rw_n; nack_q <= nack_n; oe_q <= oe_n; rdsel_q <= rdsel_n;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_idx  = idx_q;
  assign wr_data = sh_q;
endmodule

// File: rtl/div_cfg_regs.sv
module div_cfg_regs
  import synth_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mr_s,
  input  logic       mr_rise,
  input  logic       pload_s,
  input  div_cfg_t   par_cfg,
  input  logic       wr_strobe,
  input  logic [1:0] wr_idx,
  input  logic [7:0] wr_data,
  output div_cfg_t   act_cfg,
  output logic [7:0] stg_lo,
  output logic [7:0] stg_hi
);
  div_cfg_t act_q, act_n;
  logic [7:0] lo_q, lo_n, hi_q, hi_n;
  logic cmd_hit;
  logic [15:0] act_word;

  assign cmd_hit  = wr_strobe && (wr_idx == 2'd0);
  assign act_word = cfg_to_word(act_q);

  always_comb begin
    act_n = act_q;
    if (mr_rise) begin
      act_n = par_cfg;
    end else if (mr_s) begin
      if (!pload_s) begin
        act_n = par_cfg;
      end else if (cmd_hit) begin
        unique case (wr_data)
          OP_LOAD: act_n = word_to_cfg({hi_q, lo_q});
          OP_INC:  if (act_q.m != M_MAX) act_n.m = act_q.m + 1'b1;
          OP_DEC:  if (act_q.m != '0)    act_n.m = act_q.m - 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    if (cmd_hit && wr_data == OP_GET) begin
      lo_n = act_word[7:0];
      hi_n = act_word[15:8];
    end else if (wr_strobe && wr_idx == 2'd1) begin
      lo_n = wr_data;
    end else if (wr_strobe && wr_idx == 2'd2) begin
      hi_n = {1'b0, wr_data[6:0]};
    end
  end

  localparam logic [15:0] DEF_WORD = {1'b0, DEF_CFG};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= DEF_CFG;
      lo_q  <= DEF_WORD[7:0];
      hi_q  <= DEF_WORD[15:8];
    end else begin
      act_q <= act_n;
      lo_q  <= lo_n;
      hi_q  <= hi_n;
    end
  end

  assign act_cfg = act_q;
  assign stg_lo  = lo_q;
  assign stg_hi  = hi_q;
endmodule

// File: rtl/synth_cfg_i2c.sv
module synth_cfg_i2c
  import synth_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b10110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  input  logic        mr_n,
  input  logic        pload,
  input  logic [9:0]  par_m,
  input  logic [2:0]  par_na,
  input  logic        par_nb,
  input  logic        par_p,
  output logic [9:0]  m_out,
  output logic [2:0]  na_out,
  output logic        nb_out,
  output logic        p_out,
  output logic        serial_mode
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic mr_s, mr_rise, pload_s;
  logic wr_strobe;
  logic [1:0] wr_idx;
  logic [7:0] wr_data, stg_lo, stg_hi;
  div_cfg_t par_cfg, act_cfg;

  assign par_cfg = '{p: par_p, nb: par_nb, na: par_na, m: par_m};

  line_events #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .mr_n_in(mr_n), .pload_in(pload),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .mr_s(mr_s), .mr_rise(mr_rise), .pload_s(pload_s)
  );

  i2c_tgt_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .rd_lo(stg_lo), .rd_hi(stg_hi),
    .sda_oe(sda_oe), .wr_strobe(wr_strobe), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  div_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .mr_s(mr_s), .mr_rise(mr_rise),
    .pload_s(pload_s), .par_cfg(par_cfg),
    .wr_strobe(wr_strobe), .wr_idx(wr_idx), .wr_data(wr_data),
    .act_cfg(act_cfg), .stg_lo(stg_lo), .stg_hi(stg_hi)
  );

  assign m_out       = act_cfg.m;
  assign na_out      = act_cfg.na;
  assign nb_out      = act_cfg.nb;
  assign p_out       = act_cfg.p;
  assign serial_mode = pload_s;
endmodule

// File: rtl/synth_cfg_i2c_chk.sv
module synth_cfg_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       mr_s,
  input logic       mr_rise,
  input logic       pload_s,
  input logic       wr_strobe,
  input logic [1:0] wr_idx,
  input logic [7:0] wr_data,
  input logic [9:0] m_out,
  input logic [9:0] par_m,
  input logic [7:0] stg_lo
);
  logic serial_cmd;
  assign serial_cmd = wr_strobe && wr_idx == 2'd0 && mr_s && !mr_rise && pload_s;

  // R11: data line released after a STOP
  a_r11_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R6: increment saturates at the top
  a_r6_inc_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_cmd && wr_data == 8'h03) |=>
      (m_out == (($past(m_out) == 10'd1023) ? 10'd1023 : $past(m_out) + 10'd1)));

  // R6: decrement saturates at zero
  a_r6_dec_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_cmd && wr_data == 8'h04) |=>
      (m_out == (($past(m_out) == 10'd0) ? 10'd0 : $past(m_out) - 10'd1)));

  // R9: master-reset release captures the pins
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    mr_rise |=> m_out == $past(par_m));

  // R10: parallel mode tracks the pins
  a_r10_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_s && !pload_s) |=> m_out == $past(par_m));

  // R3: low staging byte only moves on a byte strobe
  a_r3_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> $stable(stg_lo));
endmodule

bind synth_cfg_i2c synth_cfg_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_det(stop_det), .sda_oe(sda_oe),
  .mr_s(mr_s), .mr_rise(mr_rise), .pload_s(pload_s),
  .wr_strobe(wr_strobe), .wr_idx(wr_idx), .wr_data(wr_data),
  .m_out(m_out), .par_m(par_m), .stg_lo(stg_lo)
);

// File: tb/test_synth_cfg_i2c.sv
`timescale 1ns/1ps
module test_synth_cfg_i2c;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic mr_n = 1'b1, pload = 1'b1;
  logic [14:0] pins = 15'h0007;
  logic sda_oe, sda_bus;
  logic [9:0] m_out; logic [2:0] na_out; logic nb_out, p_out, serial_mode;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  synth_cfg_i2c i_synth_cfg_i2c (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .mr_n(mr_n), .pload(pload),
    .par_m(pins[9:0]), .par_na(pins[12:10]), .par_nb(pins[13]), .par_p(pins[14]),
    .m_out(m_out), .na_out(na_out), .nb_out(nb_out), .p_out(p_out),
    .serial_mode(serial_mode)
  );

  function automatic logic [14:0] act();
    return {p_out, nb_out, na_out, m_out};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0; tick(HALF);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    b = sda_bus; scl_m = 1'b0; tick(HALF);
  endtask

  task automatic wr_byte(logic [7:0] v, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(nb);
    ack = ~nb;
  endtask

  task automatic rd_byte(logic last, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(last);
  endtask

  function automatic logic [7:0] dev_addr(logic rw);
    return {5'b10110, addr_sel, rw};
  endfunction

  // command, then n data bytes from data
  task automatic wr_txn(logic [7:0] cmd, int n, logic [7:0] lo, logic [7:0] hi);
    logic a;
    bus_start();
    wr_byte(dev_addr(1'b0), a);
    wr_byte(cmd, a);
    if (n > 0) wr_byte(lo, a);
    if (n > 1) wr_byte(hi, a);
    bus_stop();
    tick(6);
  endtask

  task automatic rd_txn(output logic [7:0] lo, output logic [7:0] hi);
    logic a;
    bus_start();
    wr_byte(dev_addr(1'b1), a);
    rd_byte(1'b0, lo);
    rd_byte(1'b1, hi);
    bus_stop();
    tick(6);
  endtask

  task automatic chk_stage(string tag, logic [7:0] elo, logic [7:0] ehi);
    logic [7:0] lo, hi;
    rd_txn(lo, hi);
    chk({tag, " low"}, lo, elo);
    chk({tag, " high"}, hi, ehi);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] lo, hi;
    logic [14:0] cur;
    tick(5); rst_n = 1'b1; tick(5);

    // R8 reset state
    chk("R8 active default", act(), {1'b1, 1'b0, 3'd2, 10'd500});
    chk("R8 sda released", sda_oe, 1'b0);
    chk("R10 serial_mode", serial_mode, 1'b1);
    chk_stage("R8 R2 default staging", 8'hF4, 8'h49);

    // R1 address sweep
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      for (int t = 0; t < 8; t++) begin
        logic [6:0] ad;
        ad = (t < 4) ? {5'b10110, 2'(t)} : {5'(t * 5), 2'(s)};
        bus_start();
        wr_byte({ad, 1'b0}, a);
        bus_stop(); tick(4);
        chk("R1 address ack", a, (ad == {5'b10110, 2'(s)}));
      end
    end
    addr_sel = 2'b10;
    chk("R1 no side effect", act(), {1'b1, 1'b0, 3'd2, 10'd500});

    // R3 / R2 staging sweep without LOAD
    for (int k = 0; k < 16; k++) begin
      lo = 8'(k * 17); hi = 8'(k * 37 + 128);
      wr_txn(8'h00, 2, lo, hi);
      chk_stage("R3 R2 staging roundtrip", lo, {1'b0, hi[6:0]});
      chk("R3 active untouched", act(), {1'b1, 1'b0, 3'd2, 10'd500});
    end

    // R3 extra byte ignored
    bus_start();
    wr_byte(dev_addr(1'b0), a); wr_byte(8'h00, a); wr_byte(8'h3C, a);
    wr_byte(8'h15, a); wr_byte(8'hAA, a);
    chk("R3 extra byte acked", a, 1'b1);
    bus_stop(); tick(6);
    chk_stage("R3 extra byte ignored", 8'h3C, 8'h15);

    // R4 LOAD patterns, R12 readback after command
    for (int k = 0; k < 6; k++) begin
      lo = 8'(k * 53 + 7); hi = 8'(k * 29 + 3);
      wr_txn(8'h00, 2, lo, hi);
      wr_txn(8'h01, 0, 8'h00, 8'h00);
      chk("R4 load", act(), {hi[6:0], lo});
      chk_stage("R12 read after command", lo, {1'b0, hi[6:0]});
    end

    // R6 INC/DEC with saturation
    wr_txn(8'h00, 2, 8'h05, 8'h40);
    wr_txn(8'h01, 0, 8'h00, 8'h00);
    wr_txn(8'h03, 0, 8'h00, 8'h00);
    chk("R6 inc", m_out, 10'd6);
    wr_txn(8'h04, 0, 8'h00, 8'h00);
    wr_txn(8'h04, 0, 8'h00, 8'h00);
    chk("R6 dec", m_out, 10'd4);
    chk_stage("R6 staging untouched", 8'h05, 8'h40);
    wr_txn(8'h00, 2, 8'hFF, 8'h03);
    wr_txn(8'h01, 0, 8'h00, 8'h00);
    wr_txn(8'h03, 0, 8'h00, 8'h00);
    chk("R6 inc saturates", m_out, 10'd1023);
    wr_txn(8'h00, 2, 8'h00, 8'h00);
    wr_txn(8'h01, 0, 8'h00, 8'h00);
    wr_txn(8'h04, 0, 8'h00, 8'h00);
    chk("R6 dec saturates", m_out, 10'd0);

    // R5 GET after INC
    wr_txn(8'h03, 0, 8'h00, 8'h00);
    wr_txn(8'h03, 0, 8'h00, 8'h00);
    wr_txn(8'h02, 0, 8'h00, 8'h00);
    chk_stage("R5 get", 8'h02, 8'h00);

    // R7 unknown codes
    cur = act();
    wr_txn(8'h55, 0, 8'h00, 8'h00);
    wr_txn(8'hFF, 0, 8'h00, 8'h00);
    chk("R7 unknown no active change", act(), cur);
    chk_stage("R7 unknown no staging change", 8'h02, 8'h00);

    // R11 aborts: STOP and repeated START inside a byte
    bus_start();
    wr_byte(dev_addr(1'b0), a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop(); tick(6);
    chk("R11 released after stop", sda_oe, 1'b0);
    chk("R11 active after stop abort", act(), cur);
    bus_start();
    wr_byte(dev_addr(1'b0), a);
    wr_byte(8'h00, a);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start();
    wr_byte(dev_addr(1'b1), a);
    chk("R11 repeated start addresses", a, 1'b1);
    rd_byte(1'b0, lo); rd_byte(1'b1, hi);
    bus_stop(); tick(6);
    chk("R11 partial byte discarded low", lo, 8'h02);
    chk("R11 partial byte discarded high", hi, 8'h00);

    // R9 master reset capture in serial mode
    mr_n = 1'b0; tick(4);
    pins = {1'b0, 1'b1, 3'd5, 10'd777}; tick(6);
    chk("R9 hold while mr low", act(), cur);
    mr_n = 1'b1; tick(6);
    chk("R9 capture on release", act(), {1'b0, 1'b1, 3'd5, 10'd777});
    pins = {1'b1, 1'b0, 3'd1, 10'd33}; tick(6);
    chk("R10 pins ignored in serial", act(), {1'b0, 1'b1, 3'd5, 10'd777});

    // R10 parallel mode tracks pins, commands ignored
    pload = 1'b0; tick(6);
    chk("R10 serial_mode low", serial_mode, 1'b0);
    chk("R10 follows pins", act(), {1'b1, 1'b0, 3'd1, 10'd33});
    for (int k = 0; k < 4; k++) begin
      pins = 15'(k * 4111 + 99); tick(6);
      chk("R10 follows pin pattern", act(), 15'(k * 4111 + 99));
    end
    wr_txn(8'h03, 0, 8'h00, 8'h00);
    chk("R10 command ignored", act(), pins);
    wr_txn(8'h02, 0, 8'h00, 8'h00);
    chk_stage("R5 get in parallel mode", pins[7:0], {1'b0, pins[14:8]});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule